// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This unit sits between a processor's load/store path and main memory. Each logical address the processor presents is moved into physical memory by adding a relocation base. The address is also tested against the size of the running process's address space. An access that lands outside that space is not passed on. Instead the unit raises a fault flag, which the operating system takes as a segmentation trap.

The base and the size are held in two registers. The operating system reloads them at every context switch, and only while the privilege input shows supervisor mode. The bounds test has two forms, selected for each request:

- **Limit form:** compares the logical address with the size before the add.
- **Range form:** compares the relocated address with the window from base up to base plus size.

Results come out registered, one cycle after the request.

Top module: `mmu_reloc`

## Requirements
- R1: After reset, base and size are both zero, and `rsp_valid`, `rsp_fault`, `rsp_paddr` and `priv_err` are all low. Every request that follows then faults, until supervisor software programs the registers.
- R2: A request accepted in cycle N gives `rsp_valid` = 1 in cycle N+1 when its check passes. In that case `rsp_paddr` = `req_laddr` + base, zero-extended to the physical width.
- R3: With `range_mode` = 0 (limit form), a request faults when the logical address is greater than or equal to the size, and passes when it is strictly less.
- R4: With `range_mode` = 1 (range form), a request passes only when base <= physical address < base + size. Otherwise it faults.
- R5: When `req_laddr` + base carries out of the physical width, the request faults in both forms.
- R6: When a request faults, `rsp_fault` is 1 in cycle N+1, `rsp_valid` stays 0 and `rsp_paddr` is 0, so no address reaches memory.
- R7: Each request yields exactly one of `rsp_valid` or `rsp_fault` in the next cycle. A cycle with no request yields neither in the following cycle.
- R8: A write with `sup_mode` = 1 and `reg_we` = 1 loads `reg_wdata` into the register chosen by `reg_sel`: 0 selects base, 1 selects size. The new value applies to requests from the next cycle on. A request made in the same cycle as the write still uses the old value.
- R9: A write with `sup_mode` = 0 leaves both registers unchanged and sets `priv_err` to 1 in the next cycle. `priv_err` is 0 after a supervisor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sup_mode | input | 1 | 1 = supervisor privilege |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = base, 1 = size |
| reg_wdata | input | PA_W | Register write data |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | LA_W | Logical address |
| range_mode | input | 1 | 0 = limit form, 1 = range form |
| rsp_valid | output | 1 | Translated address is valid |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Bounds or overflow trap |
| priv_err | output | 1 | User-mode register write attempted |

## Verification
The hardest case to reach from the ports is the carry out of the relocation add. It needs a base within one logical span of the top of physical memory, together with a size large enough that the bounds test alone would pass. The bench programs a base just below the top of the physical range and a size wider than the remaining room. It then probes the addresses on both sides of the wrap, in both check forms. A second hard case is a register write that coincides with a request. The bench issues both in the same cycle and checks that the old base is applied, then that the new base takes over on the next request.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic {
    CHK_LIMIT = 1'b0,
    CHK_RANGE = 1'b1
  } chk_mode_e;

  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_SIZE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mmu_regs.sv
module mmu_regs
  import mmu_pkg::*;
#(
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sup_mode,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [PA_W-1:0] wr_data,
  output logic [PA_W-1:0] base_q,
  output logic [PA_W-1:0] size_q,
  output logic            priv_err_q
);
  logic legal_wr;
  assign legal_wr = wr_en && sup_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      size_q     <= '0;
      priv_err_q <= 1'b0;
    end else begin
      priv_err_q <= wr_en && !sup_mode;
      if (legal_wr && reg_sel_e'(wr_sel) == SEL_BASE) base_q <= wr_data;
      if (legal_wr && reg_sel_e'(wr_sel) == SEL_SIZE) size_q <= wr_data;
    end
  end

  // R9: user-mode write leaves state untouched
  assert_user_wr_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sup_mode) |=> ($stable(base_q) && $stable(size_q)));

  // R8: supervisor write lands in the selected register
  assert_sup_wr_base_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sup_mode && !wr_sel) |=> (base_q == $past(wr_data)));

  assert_sup_wr_size_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sup_mode && wr_sel) |=> (size_q == $past(wr_data)));
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic [LA_W-1:0] laddr,
  input  logic [PA_W-1:0] base,
  input  logic [PA_W-1:0] size,
  input  logic            mode,
  output logic [PA_W-1:0] paddr,
  output logic            carry,
  output logic            pass
);
  localparam int SUM_W = PA_W + 1;

  logic [SUM_W-1:0] sum_w;
  logic [SUM_W-1:0] top_w;
  logic [PA_W-1:0]  laddr_ext;
  logic             lim_ok;
  logic             rng_ok;

  assign laddr_ext = PA_W'(laddr);
  assign sum_w     = {1'b0, base} + {1'b0, laddr_ext};
  assign top_w     = {1'b0, base} + {1'b0, size};
  assign paddr     = sum_w[PA_W-1:0];
  assign carry     = sum_w[PA_W];

  assign lim_ok = laddr_ext < size;
  assign rng_ok = (sum_w >= {1'b0, base}) && (sum_w < top_w);

  always_comb begin
    unique case (chk_mode_e'(mode))
      CHK_LIMIT: pass = lim_ok && !carry;
      CHK_RANGE: pass = rng_ok && !carry;
      default:   pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmu_reloc.sv
module mmu_reloc
  import mmu_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sup_mode,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [PA_W-1:0] reg_wdata,
  input  logic            req_valid,
  input  logic [LA_W-1:0] req_laddr,
  input  logic            range_mode,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            priv_err
);
  logic [PA_W-1:0] base_q, size_q, paddr_c;
  logic            carry_c, pass_c;

  mmu_regs #(.PA_W(PA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sup_mode  (sup_mode),
    .wr_en     (reg_we),
    .wr_sel    (reg_sel),
    .wr_data   (reg_wdata),
    .base_q    (base_q),
    .size_q    (size_q),
    .priv_err_q(priv_err)
  );

  mmu_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xlate (
    .laddr(req_laddr),
    .base (base_q),
    .size (size_q),
    .mode (range_mode),
    .paddr(paddr_c),
    .carry(carry_c),
    .pass (pass_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid && pass_c;
      rsp_fault <= req_valid && !pass_c;
      rsp_paddr <= (req_valid && pass_c) ? paddr_c : '0;
    end
  end

  // R7: one response kind per request, none when idle
  assert_one_resp_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid ^ rsp_fault));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_valid || rsp_fault));

  // R6: faulting access never presents an address
  assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_paddr == '0 && !rsp_valid));

  // R5: carry out of the add traps
  assert_carry_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && carry_c) |=> rsp_fault);

  // R3: limit form rejects addresses at or above the size
  assert_limit_form_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !range_mode && PA_W'(req_laddr) >= size_q) |=> rsp_fault);

  // R2: passing response carries the relocated address
  assert_reloc_sum_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_valid ||
                   rsp_paddr == PA_W'($past(PA_W'(req_laddr)) + $past(base_q))));
endmodule

// File: tb/tb_mmu_reloc.sv
module tb_mmu_reloc;
  localparam int LA_W = 16;
  localparam int PA_W = 20;
  localparam int VW   = 1 + LA_W + 1 + PA_W;
  localparam int NV   = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic            sup_mode, reg_we, reg_sel, req_valid, range_mode;
  logic [PA_W-1:0] reg_wdata;
  logic [LA_W-1:0] req_laddr;
  logic            rsp_valid, rsp_fault, priv_err;
  logic [PA_W-1:0] rsp_paddr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mmu_reloc #(.LA_W(LA_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst(rst), .sup_mode(sup_mode), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .req_valid(req_valid),
    .req_laddr(req_laddr), .range_mode(range_mode), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .priv_err(priv_err)
  );

  // {mode, laddr, expect_fault, expect_paddr} with base 0x12340, size 0x1000
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 16'h0000, 1'b0, 20'h12340},
    {1'b0, 16'h0FFF, 1'b0, 20'h1333F},
    {1'b0, 16'h1000, 1'b1, 20'h00000},
    {1'b0, 16'hFFFF, 1'b1, 20'h00000},
    {1'b1, 16'h0800, 1'b0, 20'h12B40},
    {1'b1, 16'h0FFF, 1'b0, 20'h1333F},
    {1'b1, 16'h1000, 1'b1, 20'h00000},
    {1'b1, 16'h0000, 1'b0, 20'h12340}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sup, input logic sel, input logic [PA_W-1:0] d);
    @(negedge clk);
    sup_mode = sup; reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic xreq(input logic m, input logic [LA_W-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; range_mode = m; req_laddr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic f, input logic [PA_W-1:0] pa);
    chk(req, {31'b0, rsp_fault}, {31'b0, f});
    chk(req, {31'b0, rsp_valid}, {31'b0, !f});
    chk(req, 32'(rsp_paddr), 32'(pa));
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; sup_mode = 1'b0; reg_we = 1'b0; reg_sel = 1'b0;
    reg_wdata = '0; req_valid = 1'b0; req_laddr = '0; range_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 valid", {31'b0, rsp_valid}, 0);
    chk("R1 fault", {31'b0, rsp_fault}, 0);
    chk("R1 paddr", 32'(rsp_paddr), 0);
    chk("R1 priv", {31'b0, priv_err}, 0);
    xreq(1'b0, 16'h0000);
    expect_rsp("R1 limit form faults at zero size", 1'b1, '0);
    xreq(1'b1, 16'h0000);
    expect_rsp("R1 range form faults at zero size", 1'b1, '0);

    // R8 program registers
    wr(1'b1, 1'b0, 20'h12340);
    chk("R8 priv after sup write", {31'b0, priv_err}, 0);
    wr(1'b1, 1'b1, 20'h01000);

    // table walk R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      xreq(v[VW-1], v[VW-2 -: LA_W]);
      expect_rsp($sformatf("R2/R3/R4/R6 vec %0d", i), v[PA_W], v[PA_W-1:0]);
    end

    // R7 idle cycle gives nothing
    @(negedge clk);
    chk("R7 idle valid", {31'b0, rsp_valid}, 0);
    chk("R7 idle fault", {31'b0, rsp_fault}, 0);

    // R9 user write ignored, flag pulses
    @(negedge clk);
    sup_mode = 1'b0; reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 20'h55555;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R9 priv_err set", {31'b0, priv_err}, 1);
    xreq(1'b0, 16'h0010);
    expect_rsp("R9 base unchanged", 1'b0, 20'h12350);
    chk("R9 priv_err clears", {31'b0, priv_err}, 0);
    wr(1'b0, 1'b1, 20'h00000);
    xreq(1'b0, 16'h0FFF);
    expect_rsp("R9 size unchanged", 1'b0, 20'h1333F);

    // R8 write and request in the same cycle
    @(negedge clk);
    sup_mode = 1'b1; reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 20'h20000;
    req_valid = 1'b1; range_mode = 1'b0; req_laddr = 16'h0004;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    expect_rsp("R8 same-cycle uses old base", 1'b0, 20'h12344);
    xreq(1'b0, 16'h0004);
    expect_rsp("R8 next request uses new base", 1'b0, 20'h20004);

    // R5 carry near the top of physical space
    wr(1'b1, 1'b0, 20'hFFF00);
    wr(1'b1, 1'b1, 20'h01000);
    xreq(1'b0, 16'h00FF);
    expect_rsp("R5 last address fits", 1'b0, 20'hFFFFF);
    xreq(1'b0, 16'h0100);
    expect_rsp("R5 carry limit form", 1'b1, '0);
    xreq(1'b1, 16'h0100);
    expect_rsp("R5 carry range form", 1'b1, '0);
    xreq(1'b1, 16'h00FF);
    expect_rsp("R4 range form top fits", 1'b0, 20'hFFFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule